// File: doc/BRIEF.md
# Far-End Alarm Code Word Receiver

This block watches the serial alarm-and-control channel extracted from a DS3 frame, one bit per strobe. It finds code words made of an eight-ones flag followed by a byte that wraps six message bits between two zero framing bits. It counts how many identical valid code words arrive back to back. When that count reaches the qualification threshold, it stores the six message bits, sets a status flag and, if enabled, raises an interrupt.

A processor reads the stored message and the status flag through a read strobe, and the read clears the status. A continuous stream of ones is the idle pattern. It never produces a message. Under steady reception of one message, the counter restarts after each qualified group, so the interrupt comes back once per group.

Top module: `alarm_code_rx`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears msg_out, stat_out and irq_out to 0, and the repetition count to 0.
- R2: A bit is taken only on a cycle with bit_vld high. In arrival order, a code word is eight 1s, then a 0, then message bits b0..b5, then a 0. msg_out[i] holds bi.
- R3: On the strobe edge that completes the 10th consecutive identical valid code word, msg_out takes the message and stat_out goes to 1. Neither changes after the 9th.
- R4: irq_out is 1 exactly when stat_out is 1 and irq_en is 1. stat_out is set whatever irq_en is.
- R5: A cycle with rd_stb high and no qualification clears stat_out at that edge. msg_out keeps its value.
- R6: An unbroken stream of 1s never sets stat_out.
- R7: A valid code word whose message differs from the previous one restarts the count at 1.
- R8: A malformed code word resets the count to 0. A code word is malformed when a framing bit is 1 or the flag is broken. Once the block has locked onto code word boundaries, a malformed word also makes it look for those boundaries again.
- R9: After a qualification the count returns to 0, so the next 10 identical code words qualify again.
- R10: When a qualification and rd_stb fall on the same edge, stat_out ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_vld | input | 1 | One-cycle strobe marking a valid channel bit |
| bit_in | input | 1 | Channel bit, sampled when bit_vld is high |
| irq_en | input | 1 | Receive interrupt enable |
| rd_stb | input | 1 | Processor read of the message/status word; clears status |
| msg_out | output | 6 | Last qualified message, b0 in bit 0 |
| stat_out | output | 1 | Receive status, set on qualification |
| irq_out | output | 1 | Interrupt, status gated by irq_en |

## Verification
The assertions take bit_vld as a single-cycle strobe whose bit_in is meaningful only on that cycle. They also take rd_stb as a pulse that may land on any cycle, including a qualifying one. The stimulus holds bit_vld high for one cycle, then leaves it low for at least one cycle. It changes bit_in only together with the strobe.

Between scenarios the bench puts the count back to zero with a burst of idle ones. This keeps each expected count a plain sum of the code words sent since that burst. The sweep covers all 64 message values.

// File: rtl/alarm_code_pkg.sv
// alarm_code_pkg: shared sizes and types for the far-end alarm code receiver.
// Assumes the code word is flag, trailing zero, message, leading zero.
package alarm_code_pkg;
    localparam int FLAG_BITS = 8;
    localparam int MSG_BITS  = 6;
    localparam int WORD_BITS = FLAG_BITS + MSG_BITS + 2;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } frame_state_t;
endpackage

// File: rtl/alarm_code_frame.sv
// alarm_code_frame: slides the incoming bits through a window, finds code word
// boundaries, then checks each aligned word. It emits a one-cycle ok or bad
// pulse, together with the message carried by the word.
// Assumes bit_in is meaningful only while bit_vld is high.
module alarm_code_frame
    import alarm_code_pkg::*;
#(
    parameter int FLAG_W = FLAG_BITS,
    parameter int MSG_W  = MSG_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic             word_ok,
    output logic             word_bad,
    output logic [MSG_W-1:0] word_msg
);
    localparam int CW_W  = FLAG_W + MSG_W + 2;
    localparam int PH_W  = $clog2(CW_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CW_W - 1);

    logic [CW_W-2:0] hist_q;
    logic [CW_W-1:0] win;
    logic [PH_W-1:0] phase_q;
    frame_state_t    state_q;
    logic            flag_good;
    logic            frame_good;
    logic            word_good;

    // window holds the last CW_W bits, the earliest bit at index 0
    assign win        = {bit_in, hist_q};
    assign flag_good  = &win[FLAG_W-1:0];
    assign frame_good = !win[FLAG_W] && !win[CW_W-1];
    assign word_good  = flag_good && frame_good;
    assign word_msg   = win[FLAG_W+MSG_W:FLAG_W+1];

    // shift register of past bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (bit_vld)
            hist_q <= win[CW_W-1:1];
    end

    // word event decode: any match while hunting, aligned check while locked
    always_comb begin
        word_ok  = 1'b0;
        word_bad = 1'b0;
        if (bit_vld) begin
            if (state_q == ST_HUNT) begin
                word_ok = word_good;
            end else if (phase_q == PH_LAST) begin
                word_ok  = word_good;
                word_bad = !word_good;
            end
        end
    end

    // boundary tracking: lock on a match, drop lock on a malformed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            phase_q <= '0;
        end else if (bit_vld) begin
            if (state_q == ST_HUNT) begin
                if (word_good) begin
                    state_q <= ST_LOCK;
                    phase_q <= '0;
                end
            end else if (phase_q == PH_LAST) begin
                phase_q <= '0;
                if (!word_good)
                    state_q <= ST_HUNT;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // R2: the bit position moves only on a strobe
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(phase_q) && $stable(state_q));
    // R8: a bad word is reported only while locked and always drops the lock
    p_bad_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_bad |=> state_q == ST_HUNT);
    // R2: ok and bad are never reported together
    p_one_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_ok && word_bad));
endmodule

// File: rtl/alarm_code_qual.sv
// alarm_code_qual: counts back-to-back identical valid words. On the REPS-th
// word it stores the message and sets status. A read clears the status, but a
// qualification on the same edge wins.
// Assumes word_ok and word_bad are one-cycle pulses that never coincide.
module alarm_code_qual #(
    parameter int MSG_W = 6,
    parameter int REPS  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_ok,
    input  logic             word_bad,
    input  logic [MSG_W-1:0] word_msg,
    input  logic             rd_stb,
    output logic [MSG_W-1:0] msg_q,
    output logic             stat_q
);
    localparam int CNT_W = $clog2(REPS + 1);
    localparam logic [CNT_W-1:0] REPS_V = CNT_W'(REPS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [MSG_W-1:0] last_q;
    logic             qualify;

    // next count: extend a run of equal words, otherwise start a new run at 1
    always_comb begin
        if (cnt_q != '0 && word_msg == last_q)
            cnt_nxt = cnt_q + 1'b1;
        else
            cnt_nxt = CNT_W'(1);
    end

    assign qualify = word_ok && (cnt_nxt == REPS_V);

    // repetition run state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else if (word_bad) begin
            cnt_q <= '0;
        end else if (word_ok) begin
            last_q <= word_msg;
            cnt_q  <= qualify ? '0 : cnt_nxt;
        end
    end

    // stored message and status flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_q  <= '0;
            stat_q <= 1'b0;
        end else if (qualify) begin
            msg_q  <= word_msg;
            stat_q <= 1'b1;
        end else if (rd_stb) begin
            stat_q <= 1'b0;
        end
    end

    // R3: the run never reaches the threshold as a stored value
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < REPS_V);
    // R3: status rises only after a completed word
    p_rise_needs_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q) |-> $past(word_ok));
    // R5: a read without a qualification clears status and holds the message
    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !word_ok |=> !stat_q && $stable(msg_q));
    // R8: a malformed word empties the run
    p_bad_resets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_bad |=> cnt_q == '0);
    // R9: the run restarts after a qualification
    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        qualify |=> cnt_q == '0 && stat_q);
endmodule

// File: rtl/alarm_code_rx.sv
// alarm_code_rx: top of the far-end alarm code receiver. It joins the word
// framer to the repetition qualifier and gates the status with the interrupt
// enable.
// Assumes one channel bit per bit_vld pulse and a synchronous active-low reset.
module alarm_code_rx
    import alarm_code_pkg::*;
#(
    parameter int FLAG_W = FLAG_BITS,
    parameter int MSG_W  = MSG_BITS,
    parameter int REPS   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic             irq_en,
    input  logic             rd_stb,
    output logic [MSG_W-1:0] msg_out,
    output logic             stat_out,
    output logic             irq_out
);
    logic             word_ok;
    logic             word_bad;
    logic [MSG_W-1:0] word_msg;

    alarm_code_frame #(.FLAG_W(FLAG_W), .MSG_W(MSG_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .word_ok  (word_ok),
        .word_bad (word_bad),
        .word_msg (word_msg)
    );

    alarm_code_qual #(.MSG_W(MSG_W), .REPS(REPS)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_ok  (word_ok),
        .word_bad (word_bad),
        .word_msg (word_msg),
        .rd_stb   (rd_stb),
        .msg_q    (msg_out),
        .stat_q   (stat_out)
    );

    // interrupt output: status masked by the enable
    assign irq_out = stat_out && irq_en;

    // R4: with the enable low the interrupt stays quiet whatever the status
    p_irq_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_out && !irq_en |-> !irq_out);
endmodule

// File: tb/alarm_code_rx_test.sv
// alarm_code_rx_test: directed scenarios plus a sweep over all 64 messages.
module alarm_code_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       irq_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic [5:0] msg_out;
    logic       stat_out;
    logic       irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alarm_code_rx uut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .irq_en(irq_en), .rd_stb(rd_stb), .msg_out(msg_out),
        .stat_out(stat_out), .irq_out(irq_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic rd = 1'b0);
        @(negedge clk);
        bit_vld = 1'b1; bit_in = b; rd_stb = rd;
        @(negedge clk);
        bit_vld = 1'b0; rd_stb = 1'b0;
    endtask

    // arrival order: 8 ones, trailing 0, b0..b5, leading bit (0 when well formed)
    task automatic send_word(input logic [5:0] m, input logic lead = 1'b0,
                             input logic rd_last = 1'b0);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(m[i]);
        send_bit(lead, rd_last);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic do_read();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 msg", int'(msg_out), 0);
        check("R1 stat", int'(stat_out), 0);
        check("R1 irq", int'(irq_out), 0);
        rst_n = 1'b1;

        // R3: nine words do nothing, the tenth qualifies; R2 bit order
        for (int k = 0; k < 9; k++) send_word(6'h25);
        check("R3 no stat after 9", int'(stat_out), 0);
        send_word(6'h25);
        check("R3 stat after 10", int'(stat_out), 1);
        check("R2 msg order", int'(msg_out), 'h25);
        // R4 enable gating
        check("R4 irq masked", int'(irq_out), 0);
        irq_en = 1'b1; @(negedge clk);
        check("R4 irq enabled", int'(irq_out), 1);
        // R5 read clears, message kept
        do_read();
        check("R5 stat cleared", int'(stat_out), 0);
        check("R5 irq cleared", int'(irq_out), 0);
        check("R5 msg held", int'(msg_out), 'h25);

        // R6 idle stream
        send_idle(400);
        check("R6 idle no stat", int'(stat_out), 0);

        // R7 different message restarts count
        for (int k = 0; k < 5; k++) send_word(6'h0A);
        for (int k = 0; k < 9; k++) send_word(6'h31);
        check("R7 no stat after 9 new", int'(stat_out), 0);
        send_word(6'h31);
        check("R7 stat after 10 new", int'(stat_out), 1);
        check("R7 msg", int'(msg_out), 'h31);
        do_read();
        send_idle(32);

        // R8 malformed word resets count
        for (int k = 0; k < 5; k++) send_word(6'h15);
        send_word(6'h15, 1'b1);
        for (int k = 0; k < 9; k++) send_word(6'h15);
        check("R8 no stat after bad+9", int'(stat_out), 0);
        send_word(6'h15);
        check("R8 stat after bad+10", int'(stat_out), 1);
        check("R8 msg", int'(msg_out), 'h15);
        do_read();
        send_idle(32);

        // R9 re-arm after qualification
        for (int k = 0; k < 10; k++) send_word(6'h3F);
        check("R9 first group", int'(stat_out), 1);
        do_read();
        for (int k = 0; k < 9; k++) send_word(6'h3F);
        check("R9 no stat at 19", int'(stat_out), 0);
        send_word(6'h3F);
        check("R9 second group", int'(stat_out), 1);
        do_read();
        send_idle(32);

        // R10 read on the qualifying edge
        for (int k = 0; k < 9; k++) send_word(6'h07);
        send_word(6'h07, 1'b0, 1'b1);
        check("R10 set wins over read", int'(stat_out), 1);
        check("R10 msg", int'(msg_out), 'h07);
        do_read();
        send_idle(32);

        // R2/R3 sweep of all messages
        for (int m = 0; m < 64; m++) begin
            for (int k = 0; k < 10; k++) send_word(6'(m));
            check("R3 sweep stat", int'(stat_out), 1);
            check("R2 sweep msg", int'(msg_out), m);
            do_read();
        end

        // R1 reset mid-stream
        for (int k = 0; k < 10; k++) send_word(6'h2A);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset stat", int'(stat_out), 0);
        check("R1 reset msg", int'(msg_out), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule